// File: doc/BRIEF.md
# Register-Indirect Operand Address Generator

This block serves the register-indirect operand accesses of a 16-bit CPU with eight general registers. It holds the eight pointer registers. For each access it drives one or two memory transactions. It moves the selected pointer according to that register's role, assembles the operand, and reports what the access costs in CPU cycles. A 3-bit selector picks the pointer and a direction bit picks read or write. A one-shot double-byte mode makes a read build one 16-bit value from the low bytes of two neighbouring words.

Registers 0 to 3 are plain pointers. Registers 4, 5 and 7 step forward after use. Register 6 works as a stack: a read pops it and a write pushes it. The double-byte mode is armed by an instruction-completion strobe together with a set request. It drops at the next completion that comes without a set. The mode an access uses is captured when that access is accepted.

Top module: `ind_addr_gen`

## Requirements
- R1: After reset all eight pointers read 0, `dbd_mode` is 0, `req_ready` is 1 and no memory request or response is active.
- R2: A single-word access, read or write, through registers 0 to 3 leaves the pointer unchanged and uses its value as the address.
- R3: An access through register 4, 5 or 7 uses the current pointer as the address and adds 1 to the pointer afterwards, for both reads and writes.
- R4: A read through register 6 subtracts 1 from the pointer and then reads at the new value. A write through register 6 stores at the current value and then adds 1.
- R5: A read in double-byte mode reads two consecutive addresses, lower address first. Bits 7:0 of the first word give result bits 7:0 and bits 7:0 of the second word give result bits 15:8. The pointer gains 1 between the two reads. Registers 4, 5 and 7 gain one more afterwards, so they end at +2. Registers 0 to 3 end at +1. Register 6 returns to its value before the access.
- R6: `rsp_cycles` is 8 for a single-word read through registers 0 to 5 or 7, 11 for a single-word read through register 6, 10 for any double-byte read, and 9 for any write.
- R7: When `instr_done` is 1, `dbd_mode` takes the value of `dbd_set` on the next cycle. Otherwise it holds its value. An access uses the mode value captured at acceptance, even if the mode changes while the access is in progress.
- R8: A write is always one single-word transaction of `req_wdata`, whatever the mode.
- R9: All pointer arithmetic wraps modulo 2^16: 0xFFFF+1 gives 0 and 0-1 gives 0xFFFF.
- R10: `mem_valid` stays high with a steady address and direction until `mem_ready` is seen. Each accepted access produces exactly one `rsp_valid` pulse, one cycle wide, and `req_ready` is high exactly when no memory request is pending.
- R11: A pulse on `ptr_wr_en` loads `ptr_wr_data` into the register `ptr_wr_sel`, and `ptr_rd_data` shows the register `ptr_rd_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Start an indirect access |
| req_ready | output | 1 | Block is idle and accepts an access |
| req_sel | input | 3 | Pointer register used by the access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 16 | Data stored by a write |
| instr_done | input | 1 | An instruction has completed |
| dbd_set | input | 1 | The completing instruction arms double-byte mode |
| dbd_mode | output | 1 | Current double-byte mode |
| ptr_wr_en | input | 1 | Load a pointer register |
| ptr_wr_sel | input | 3 | Register to load |
| ptr_wr_data | input | 16 | Value to load |
| ptr_rd_sel | input | 3 | Register shown on ptr_rd_data |
| ptr_rd_data | output | 16 | Current value of the selected register |
| mem_valid | output | 1 | Memory request pending |
| mem_ready | input | 1 | Memory accepts the request this cycle |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 16 | Request address |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid while mem_valid and mem_ready |
| rsp_valid | output | 1 | One-cycle pulse: access finished |
| rsp_data | output | 16 | Assembled read operand, or the stored word for a write |
| rsp_cycles | output | 4 | CPU cycle cost of the access |

## Verification
The mode update and an in-flight access can fall in the same time window. The bench accepts a double-byte read and, in the very next cycle, drives a completion strobe without a set request while the memory side is still stalling. The expected result is a two-byte assembly costing 10 cycles, followed by `dbd_mode` reading 0. A second collision is a pointer step on the last transaction edge together with a response that the bench checks against the read-back pointer. Memory readiness follows a stall pattern, so both transaction slots are seen with and without wait cycles.

// File: rtl/iag_pkg.sv
package iag_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RD_LO = 2'd1,
    ST_RD_HI = 2'd2,
    ST_WR    = 2'd3
  } iag_state_e;
endpackage

// File: rtl/iag_rst_sync.sv
module iag_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/iag_ptr_file.sv
module iag_ptr_file #(
  parameter int DW   = 16,
  parameter int NREG = 8,
  localparam int SW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          upd_en,
  input  logic [SW-1:0] upd_sel,
  input  logic [DW-1:0] upd_val,
  input  logic          ld_en,
  input  logic [SW-1:0] ld_sel,
  input  logic [DW-1:0] ld_val,
  input  logic [SW-1:0] rd_a_sel,
  output logic [DW-1:0] rd_a_val,
  input  logic [SW-1:0] rd_b_sel,
  output logic [DW-1:0] rd_b_val
);
  logic [DW-1:0] ptr_q [NREG];

  for (genvar gi = 0; gi < NREG; gi++) begin : g_ptr
    logic          en;
    logic [DW-1:0] nxt;

    // sequencer step wins over an external load of the same register
    always_comb begin
      en  = 1'b0;
      nxt = ptr_q[gi];
      if (upd_en && (upd_sel == SW'(gi))) begin
        en  = 1'b1;
        nxt = upd_val;
      end else if (ld_en && (ld_sel == SW'(gi))) begin
        en  = 1'b1;
        nxt = ld_val;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  ptr_q[gi] <= '0;
      else if (en) ptr_q[gi] <= nxt;
    end
  end

  assign rd_a_val = ptr_q[rd_a_sel];
  assign rd_b_val = ptr_q[rd_b_sel];
endmodule

// File: rtl/iag_mode_flag.sv
module iag_mode_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic instr_done,
  input  logic mode_set,
  output logic mode_q
);
  logic mode_n;

  always_comb mode_n = mode_set;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          mode_q <= 1'b0;
    else if (instr_done) mode_q <= mode_n;
  end
endmodule

// File: rtl/iag_seq.sv
module iag_seq
  import iag_pkg::*;
#(
  parameter int DW        = 16,
  parameter int SW        = 3,
  parameter int CW        = 4,
  parameter int STACK_IDX = 6,
  parameter int INC_BASE  = 4,
  parameter int CYC_PLAIN = 8,
  parameter int CYC_STACK = 11,
  parameter int CYC_DBL   = 10,
  parameter int CYC_WR    = 9,
  localparam int HW       = DW / 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [SW-1:0] req_sel,
  input  logic          req_write,
  input  logic [DW-1:0] req_wdata,
  input  logic          dbd_mode,
  output logic [SW-1:0] ptr_sel,
  input  logic [DW-1:0] ptr_val,
  output logic          upd_en,
  output logic [DW-1:0] upd_val,
  output logic          mem_valid,
  input  logic          mem_ready,
  output logic          mem_we,
  output logic [DW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data,
  output logic [CW-1:0] rsp_cycles
);
  iag_state_e    st_q, st_n;
  logic [SW-1:0] sel_q;
  logic          dbl_q;
  logic [DW-1:0] wdata_q;
  logic [HW-1:0] lo_q, lo_n;
  logic          lo_en;
  logic          acc_en;
  logic          rsp_v_n;
  logic [DW-1:0] rsp_d_n;
  logic [CW-1:0] rsp_c_n;
  logic          sel_stack, sel_inc;

  assign ptr_sel   = (st_q == ST_IDLE) ? req_sel : sel_q;
  assign sel_stack = (ptr_sel == SW'(STACK_IDX));
  assign sel_inc   = (ptr_sel >= SW'(INC_BASE));

  assign req_ready = (st_q == ST_IDLE);
  assign mem_valid = (st_q != ST_IDLE);
  assign mem_we    = (st_q == ST_WR);
  assign mem_addr  = ptr_val;
  assign mem_wdata = wdata_q;

  always_comb begin
    st_n    = st_q;
    acc_en  = 1'b0;
    lo_en   = 1'b0;
    lo_n    = mem_rdata[HW-1:0];
    rsp_v_n = 1'b0;
    rsp_d_n = mem_rdata;
    rsp_c_n = CW'(CYC_PLAIN);
    upd_en  = 1'b0;
    upd_val = ptr_val + DW'(1);
    unique case (st_q)
      ST_IDLE: begin
        if (req_valid) begin
          acc_en = 1'b1;
          st_n   = req_write ? ST_WR : ST_RD_LO;
          if (!req_write && sel_stack) begin
            upd_en  = 1'b1;
            upd_val = ptr_val - DW'(1);
          end
        end
      end
      ST_RD_LO: begin
        if (mem_ready) begin
          if (dbl_q) begin
            lo_en  = 1'b1;
            upd_en = 1'b1;
            st_n   = ST_RD_HI;
          end else begin
            rsp_v_n = 1'b1;
            rsp_c_n = sel_stack ? CW'(CYC_STACK) : CW'(CYC_PLAIN);
            upd_en  = sel_inc && !sel_stack;
            st_n    = ST_IDLE;
          end
        end
      end
      ST_RD_HI: begin
        if (mem_ready) begin
          rsp_v_n = 1'b1;
          rsp_d_n = {mem_rdata[HW-1:0], lo_q};
          rsp_c_n = CW'(CYC_DBL);
          upd_en  = sel_inc && !sel_stack;
          st_n    = ST_IDLE;
        end
      end
      ST_WR: begin
        if (mem_ready) begin
          rsp_v_n = 1'b1;
          rsp_d_n = wdata_q;
          rsp_c_n = CW'(CYC_WR);
          upd_en  = sel_inc;
          st_n    = ST_IDLE;
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      sel_q      <= '0;
      dbl_q      <= 1'b0;
      wdata_q    <= '0;
      lo_q       <= '0;
      rsp_valid  <= 1'b0;
      rsp_data   <= '0;
      rsp_cycles <= '0;
    end else begin
      st_q      <= st_n;
      rsp_valid <= rsp_v_n;
      if (acc_en) begin
        sel_q   <= req_sel;
        dbl_q   <= dbd_mode && !req_write;
        wdata_q <= req_wdata;
      end
      if (lo_en) lo_q <= lo_n;
      if (rsp_v_n) begin
        rsp_data   <= rsp_d_n;
        rsp_cycles <= rsp_c_n;
      end
    end
  end
endmodule

// File: rtl/ind_addr_gen.sv
module ind_addr_gen #(
  parameter int DW        = 16,
  parameter int NREG      = 8,
  parameter int CW        = 4,
  parameter int STACK_IDX = 6,
  parameter int INC_BASE  = 4,
  parameter int CYC_PLAIN = 8,
  parameter int CYC_STACK = 11,
  parameter int CYC_DBL   = 10,
  parameter int CYC_WR    = 9,
  localparam int SW       = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [SW-1:0] req_sel,
  input  logic          req_write,
  input  logic [DW-1:0] req_wdata,
  input  logic          instr_done,
  input  logic          dbd_set,
  output logic          dbd_mode,
  input  logic          ptr_wr_en,
  input  logic [SW-1:0] ptr_wr_sel,
  input  logic [DW-1:0] ptr_wr_data,
  input  logic [SW-1:0] ptr_rd_sel,
  output logic [DW-1:0] ptr_rd_data,
  output logic          mem_valid,
  input  logic          mem_ready,
  output logic          mem_we,
  output logic [DW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data,
  output logic [CW-1:0] rsp_cycles
);
  logic          rst_i_n;
  logic [SW-1:0] seq_sel;
  logic [DW-1:0] seq_ptr;
  logic          seq_upd_en;
  logic [DW-1:0] seq_upd_val;

  iag_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_i_n)
  );

  iag_mode_flag u_mode (
    .clk(clk), .rst_n(rst_i_n), .instr_done(instr_done),
    .mode_set(dbd_set), .mode_q(dbd_mode)
  );

  iag_ptr_file #(.DW(DW), .NREG(NREG)) u_ptrs (
    .clk(clk), .rst_n(rst_i_n),
    .upd_en(seq_upd_en), .upd_sel(seq_sel), .upd_val(seq_upd_val),
    .ld_en(ptr_wr_en), .ld_sel(ptr_wr_sel), .ld_val(ptr_wr_data),
    .rd_a_sel(seq_sel), .rd_a_val(seq_ptr),
    .rd_b_sel(ptr_rd_sel), .rd_b_val(ptr_rd_data)
  );

  iag_seq #(
    .DW(DW), .SW(SW), .CW(CW), .STACK_IDX(STACK_IDX), .INC_BASE(INC_BASE),
    .CYC_PLAIN(CYC_PLAIN), .CYC_STACK(CYC_STACK), .CYC_DBL(CYC_DBL),
    .CYC_WR(CYC_WR)
  ) u_seq (
    .clk(clk), .rst_n(rst_i_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_sel(req_sel),
    .req_write(req_write), .req_wdata(req_wdata), .dbd_mode(dbd_mode),
    .ptr_sel(seq_sel), .ptr_val(seq_ptr),
    .upd_en(seq_upd_en), .upd_val(seq_upd_val),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_cycles(rsp_cycles)
  );
endmodule

// File: rtl/ind_addr_gen_chk.sv
module ind_addr_gen_chk #(
  parameter int DW = 16,
  parameter int CW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_ready,
  input logic          instr_done,
  input logic          dbd_set,
  input logic          dbd_mode,
  input logic          mem_valid,
  input logic          mem_ready,
  input logic          mem_we,
  input logic [DW-1:0] mem_addr,
  input logic          rsp_valid,
  input logic [CW-1:0] rsp_cycles
);
  // R10
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_we)));

  // R10
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R10
  idle_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready != mem_valid);

  // R6
  cost_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_cycles == CW'(8) || rsp_cycles == CW'(9) ||
                   rsp_cycles == CW'(10) || rsp_cycles == CW'(11)));

  // R8
  write_cost_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_ready && mem_we) |=> (rsp_valid && rsp_cycles == CW'(9)));

  // R7
  mode_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    instr_done |=> (dbd_mode == $past(dbd_set)));

  // R7
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !instr_done |=> $stable(dbd_mode));
endmodule

bind ind_addr_gen ind_addr_gen_chk #(.DW(DW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_i_n), .req_ready(req_ready), .instr_done(instr_done),
  .dbd_set(dbd_set), .dbd_mode(dbd_mode), .mem_valid(mem_valid),
  .mem_ready(mem_ready), .mem_we(mem_we), .mem_addr(mem_addr),
  .rsp_valid(rsp_valid), .rsp_cycles(rsp_cycles)
);

// File: tb/ind_addr_gen_bench.sv
module ind_addr_gen_bench;
  localparam int DW = 16;
  localparam int SW = 3;
  localparam int CW = 4;
  localparam int MD = 64;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [SW-1:0] req_sel = '0;
  logic          req_write = 1'b0;
  logic [DW-1:0] req_wdata = '0;
  logic          instr_done = 1'b0;
  logic          dbd_set = 1'b0;
  logic          dbd_mode;
  logic          ptr_wr_en = 1'b0;
  logic [SW-1:0] ptr_wr_sel = '0;
  logic [DW-1:0] ptr_wr_data = '0;
  logic [SW-1:0] ptr_rd_sel = '0;
  logic [DW-1:0] ptr_rd_data;
  logic          mem_valid;
  logic          mem_ready = 1'b0;
  logic          mem_we;
  logic [DW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic [DW-1:0] mem_rdata;
  logic          rsp_valid;
  logic [DW-1:0] rsp_data;
  logic [CW-1:0] rsp_cycles;

  always #10 clk = ~clk;

  ind_addr_gen u_ind_addr_gen (.*);

  logic [DW-1:0] tb_mem [MD];
  logic [DW-1:0] m_mem  [MD];
  logic [DW-1:0] m_ptr  [8];
  logic          m_mode;
  int            n_chk = 0;
  int            n_fail = 0;
  int            n_rsp = 0;
  int            n_acc = 0;
  int            rdy_cnt = 0;
  logic [DW-1:0] q_data [$];
  logic [CW-1:0] q_cyc  [$];
  string         q_tag  [$];

  assign mem_rdata = tb_mem[mem_addr[5:0]];

  always @(posedge clk)
    if (mem_valid && mem_ready && mem_we) tb_mem[mem_addr[5:0]] <= mem_wdata;

  // memory stalls every third cycle
  always @(negedge clk) begin
    rdy_cnt   <= rdy_cnt + 1;
    mem_ready <= (rdy_cnt % 3) != 2;
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops the scoreboard on every response
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (q_data.size() == 0) begin
        check("R10 unexpected response", 32'd1, 32'd0);
      end else begin
        string t = q_tag.pop_front();
        check({t, " data"}, 32'(rsp_data), 32'(q_data.pop_front()));
        check({t, " cycles R6"}, 32'(rsp_cycles), 32'(q_cyc.pop_front()));
      end
      n_rsp++;
    end
  end

  task automatic load_ptr(int sel, logic [DW-1:0] val);
    @(negedge clk);
    ptr_wr_en = 1'b1; ptr_wr_sel = SW'(sel); ptr_wr_data = val;
    @(negedge clk);
    ptr_wr_en = 1'b0;
    m_ptr[sel] = val;
    ptr_rd_sel = SW'(sel);
    #1 check("R11 load readback", 32'(ptr_rd_data), 32'(val));
  endtask

  task automatic set_mode(logic s);
    @(negedge clk);
    instr_done = 1'b1; dbd_set = s;
    @(negedge clk);
    instr_done = 1'b0; dbd_set = 1'b0;
    m_mode = s;
    check("R7 mode after strobe", 32'(dbd_mode), 32'(s));
  endtask

  task automatic access(string tag, int sel, logic wr, logic [DW-1:0] wd, logic clr_mid);
    logic [DW-1:0] p, d, lo, hi;
    logic [CW-1:0] c;
    int target;
    p = m_ptr[sel];
    if (wr) begin
      m_mem[p[5:0]] = wd; d = wd; c = CW'(9);
      if (sel >= 4) p = p + 16'd1;
    end else begin
      if (sel == 6) p = p - 16'd1;
      if (m_mode) begin
        lo = m_mem[p[5:0]]; p = p + 16'd1; hi = m_mem[p[5:0]];
        d = {hi[7:0], lo[7:0]}; c = CW'(10);
      end else begin
        d = m_mem[p[5:0]]; c = (sel == 6) ? CW'(11) : CW'(8);
      end
      if (sel >= 4 && sel != 6) p = p + 16'd1;
    end
    m_ptr[sel] = p;
    q_data.push_back(d); q_cyc.push_back(c); q_tag.push_back(tag);
    n_acc++;
    target = n_rsp + 1;
    @(negedge clk);
    check({tag, " R10 ready before accept"}, 32'(req_ready), 32'd1);
    req_valid = 1'b1; req_sel = SW'(sel); req_write = wr; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    if (clr_mid) begin
      instr_done = 1'b1; dbd_set = 1'b0;
      @(negedge clk);
      instr_done = 1'b0;
      m_mode = 1'b0;
    end
    while (n_rsp < target) @(negedge clk);
    ptr_rd_sel = SW'(sel);
    #1 check({tag, " pointer after"}, 32'(ptr_rd_data), 32'(p));
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R10 watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    for (int i = 0; i < MD; i++) begin
      tb_mem[i] = {8'(8'h40 + i), 8'(8'h81 + 3 * i)};
      m_mem[i]  = tb_mem[i];
    end
    for (int i = 0; i < 8; i++) m_ptr[i] = '0;
    m_mode = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    check("R1 req_ready", 32'(req_ready), 32'd1);
    check("R1 dbd_mode", 32'(dbd_mode), 32'd0);
    check("R1 mem_valid", 32'(mem_valid), 32'd0);
    check("R1 rsp_valid", 32'(rsp_valid), 32'd0);
    for (int i = 0; i < 8; i++) begin
      ptr_rd_sel = SW'(i);
      #1 check("R1 pointer zero", 32'(ptr_rd_data), 32'd0);
    end

    load_ptr(2, 16'h0010);
    access("R2 plain read", 2, 1'b0, '0, 1'b0);
    load_ptr(4, 16'h0020);
    access("R3 postinc read", 4, 1'b0, '0, 1'b0);
    load_ptr(6, 16'h0030);
    access("R4 stack pop", 6, 1'b0, '0, 1'b0);
    access("R4 stack push", 6, 1'b1, 16'hBEEF, 1'b0);
    access("R4 pop pushed", 6, 1'b0, '0, 1'b0);
    load_ptr(1, 16'h0005);
    access("R2 plain write", 1, 1'b1, 16'h1234, 1'b0);
    access("R2 read back", 1, 1'b0, '0, 1'b0);
    load_ptr(5, 16'h0025);
    access("R3 postinc write", 5, 1'b1, 16'h7777, 1'b0);

    set_mode(1'b1);
    load_ptr(5, 16'h0008);
    access("R5 double reg5", 5, 1'b0, '0, 1'b0);
    set_mode(1'b0);
    set_mode(1'b1);
    set_mode(1'b1);
    load_ptr(0, 16'h0003);
    access("R5 double reg0", 0, 1'b0, '0, 1'b0);
    load_ptr(6, 16'h0012);
    access("R5 double stack", 6, 1'b0, '0, 1'b0);
    load_ptr(4, 16'h0018);
    access("R8 write in mode", 4, 1'b1, 16'h5A5A, 1'b0);
    load_ptr(7, 16'h0020);
    access("R7 mode clear mid access", 7, 1'b0, '0, 1'b1);
    check("R7 mode cleared", 32'(dbd_mode), 32'd0);
    load_ptr(3, 16'h0018);
    access("R8 single word stored", 3, 1'b0, '0, 1'b0);
    load_ptr(3, 16'h0019);
    access("R8 neighbour untouched", 3, 1'b0, '0, 1'b0);

    load_ptr(7, 16'hFFFF);
    access("R9 wrap up", 7, 1'b0, '0, 1'b0);
    load_ptr(6, 16'h0000);
    access("R9 wrap down", 6, 1'b0, '0, 1'b0);
    access("R9 wrap push", 6, 1'b1, 16'hC3C3, 1'b0);

    repeat (4) @(negedge clk);
    check("R10 one response per access", 32'(n_rsp), 32'(n_acc));
    check("R10 scoreboard drained", 32'(q_data.size()), 32'd0);
    finish_run();
  end
endmodule